// File: doc/BRIEF.md
# Self-Test Status and Hang Indicator

This block drives one status output that serves two roles in turn. While the chip powers up, the output carries the result of the built-in self-test. The self-test engine raises a start strobe and the output goes high while the test and array initialisation run. When the engine enters result extraction, the output drops low for a fixed window of 16 cycles. After that window it settles on the verdict. A pass leaves it low. A fail latches it high until the next chip reset. An external agent can sample the level at any time after the window, because the level does not change again.

Once the self-test has passed, the same output becomes a hang indicator. A stall counter counts consecutive CPU cycles with power-up complete and no instruction retired. On the 2048th such cycle the output produces a high pulse of exactly 3 cycles, and the counter starts again from zero. A debug output shows the controller state.

Top module: `selftest_hang_indicator`

## Requirements
- R1: `rst` is synchronous and active high. At the clock edge after any cycle with `rst` high, `statusPin` is 0 and `dbgState` is 0 (reset-low).
- R2: In reset-low, a cycle with `testStart` high makes `statusPin` 1 and `dbgState` 1 from the next edge. The output stays high until `resultStart`. `resultStart` has no effect in reset-low, and `testStart` has no effect in any state other than reset-low.
- R3: A cycle with `resultStart` high while `dbgState` is 1 makes `statusPin` 0 for exactly WINDOW_LEN (16) cycles, with `dbgState` 2, starting at the next edge.
- R4: `testPass` is sampled in the last window cycle. If it is 1, `statusPin` stays 0 afterwards and `dbgState` becomes 3 (pass-idle).
- R5: If the sampled `testPass` is 0, `statusPin` becomes 1 and `dbgState` becomes 4 (fail-latched). Both hold until reset whatever the other inputs do, including any stall.
- R6: In pass-idle, once STALL_LIMIT (2048) consecutive cycles pass with `powerUpDone` 1 and `instRetired` 0, `statusPin` is 1 for exactly PULSE_LEN (3) cycles starting at the edge that ends the 2048th such cycle. During the pulse `dbgState` is 5 (timeout-pulse), and it returns to 3 afterwards.
- R7: A cycle with `instRetired` 1 clears the stall count, so 2047 idle cycles, one retirement and 2047 more idle cycles produce no pulse.
- R8: The stall count is cleared in any cycle with `powerUpDone` 0. No pulse occurs while power-up is incomplete.
- R9: The stall count restarts at zero when a pulse starts. An unbroken stall gives a pulse every 2048 cycles.
- R10: A retirement during a pulse does not shorten the pulse. It only clears the stall count.
- R11: `dbgState` encoding: 0 reset-low, 1 test-running, 2 result-window, 3 pass-idle, 4 fail-latched, 5 timeout-pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous chip reset, active high |
| testStart | input | 1 | Strobe: self-test and array initialisation begin |
| resultStart | input | 1 | Strobe: result extraction begins |
| testPass | input | 1 | Self-test verdict, 1 = pass |
| powerUpDone | input | 1 | Power-up sequence complete |
| instRetired | input | 1 | An instruction retired in this cycle |
| statusPin | output | 1 | Status / hang indicator level |
| dbgState | output | 3 | Controller state for debug (R11 encoding) |

## Verification
Every result appears one edge after the cycle whose inputs cause it. The strobes take effect at the next edge. The window covers the 16 edges after the result strobe, and the verdict appears at the 17th. A pulse covers the edge that ends the 2048th idle cycle and the two edges after it. The bench drives inputs on the falling edge and checks the outputs on the falling edge after each rising edge, so every check falls exactly one edge after its stimulus. In the pass state the bench runs an arithmetic count of idle cycles and pulse cycles and compares the output with that count on every cycle of long sweeps. The sweeps cover stalls, retirements and power-up gaps.

// File: rtl/status_pin_pkg.sv
package status_pin_pkg;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_TEST   = 3'd1,
    ST_WINDOW = 3'd2,
    ST_PASS   = 3'd3,
    ST_FAIL   = 3'd4,
    ST_PULSE  = 3'd5
  } pinState_e;

  typedef struct packed {
    logic winClr;
    logic winInc;
    logic stallClr;
    logic stallInc;
    logic pulseClr;
    logic pulseInc;
  } ctrlStrobe_t;

endpackage

// File: rtl/status_pin_counters.sv
module status_pin_counters #(
  parameter int WINDOW_LEN  = 16,
  parameter int STALL_LIMIT = 2048,
  parameter int PULSE_LEN   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  status_pin_pkg::ctrlStrobe_t strobe,
  output logic                       winDone,
  output logic                       stallHit,
  output logic                       pulseDone
);

  localparam int WW = (WINDOW_LEN  > 1) ? $clog2(WINDOW_LEN)  : 1;
  localparam int SW = (STALL_LIMIT > 1) ? $clog2(STALL_LIMIT) : 1;
  localparam int PW = (PULSE_LEN   > 1) ? $clog2(PULSE_LEN)   : 1;

  localparam logic [WW-1:0] WIN_LAST   = WW'(WINDOW_LEN - 1);
  localparam logic [SW-1:0] STALL_LAST = SW'(STALL_LIMIT - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_LEN - 1);

  logic [WW-1:0] winCnt;
  logic [SW-1:0] stallCnt;
  logic [PW-1:0] pulseCnt;

  // Clear wins over increment on each counter.
  always_ff @(posedge clk) begin
    if (rst || strobe.winClr)    winCnt <= '0;
    else if (strobe.winInc)      winCnt <= winCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.stallClr)  stallCnt <= '0;
    else if (strobe.stallInc)    stallCnt <= stallCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.pulseClr)  pulseCnt <= '0;
    else if (strobe.pulseInc)    pulseCnt <= pulseCnt + 1'b1;
  end

  assign winDone   = (winCnt   == WIN_LAST);
  assign stallHit  = (stallCnt == STALL_LAST);
  assign pulseDone = (pulseCnt == PULSE_LAST);

endmodule

// File: rtl/status_pin_ctrl.sv
module status_pin_ctrl (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        testStart,
  input  logic                        resultStart,
  input  logic                        testPass,
  input  logic                        powerUpDone,
  input  logic                        instRetired,
  input  logic                        winDone,
  input  logic                        stallHit,
  input  logic                        pulseDone,
  output status_pin_pkg::ctrlStrobe_t strobe,
  output status_pin_pkg::pinState_e   state,
  output logic                        pinLevel
);
  import status_pin_pkg::*;

  pinState_e nextState;
  logic      idleCycle;

  assign idleCycle = powerUpDone && !instRetired;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_RESET: begin
        strobe.stallClr = 1'b1;
        if (testStart) nextState = ST_TEST;
      end
      ST_TEST: begin
        strobe.stallClr = 1'b1;
        if (resultStart) begin
          nextState     = ST_WINDOW;
          strobe.winClr = 1'b1;
        end
      end
      ST_WINDOW: begin
        strobe.stallClr = 1'b1;
        if (winDone) nextState = testPass ? ST_PASS : ST_FAIL;
        else         strobe.winInc = 1'b1;
      end
      ST_PASS: begin
        if (idleCycle && stallHit) begin
          nextState       = ST_PULSE;
          strobe.stallClr = 1'b1;
          strobe.pulseClr = 1'b1;
        end else begin
          strobe.stallInc = idleCycle;
          strobe.stallClr = !idleCycle;
        end
      end
      ST_PULSE: begin
        // Stall tracking continues; a retirement only clears the count.
        strobe.stallInc = idleCycle;
        strobe.stallClr = !idleCycle;
        if (pulseDone) nextState = ST_PASS;
        else           strobe.pulseInc = 1'b1;
      end
      ST_FAIL: begin
        strobe.stallClr = 1'b1;
      end
      default: begin
        nextState       = ST_RESET;
        strobe.stallClr = 1'b1;
      end
    endcase
  end

  assign pinLevel = (state == ST_TEST) || (state == ST_FAIL) || (state == ST_PULSE);

endmodule

// File: rtl/selftest_hang_indicator.sv
module selftest_hang_indicator #(
  parameter int WINDOW_LEN  = 16,
  parameter int STALL_LIMIT = 2048,
  parameter int PULSE_LEN   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       testStart,
  input  logic       resultStart,
  input  logic       testPass,
  input  logic       powerUpDone,
  input  logic       instRetired,
  output logic       statusPin,
  output logic [2:0] dbgState
);
  import status_pin_pkg::*;

  ctrlStrobe_t strobe;
  pinState_e   state;
  logic        winDone;
  logic        stallHit;
  logic        pulseDone;

  status_pin_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .testStart   (testStart),
    .resultStart (resultStart),
    .testPass    (testPass),
    .powerUpDone (powerUpDone),
    .instRetired (instRetired),
    .winDone     (winDone),
    .stallHit    (stallHit),
    .pulseDone   (pulseDone),
    .strobe      (strobe),
    .state       (state),
    .pinLevel    (statusPin)
  );

  status_pin_counters #(
    .WINDOW_LEN  (WINDOW_LEN),
    .STALL_LIMIT (STALL_LIMIT),
    .PULSE_LEN   (PULSE_LEN)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .winDone   (winDone),
    .stallHit  (stallHit),
    .pulseDone (pulseDone)
  );

  assign dbgState = state;

endmodule

// File: rtl/selftest_hang_indicator_chk.sv
module selftest_hang_indicator_chk #(
  parameter int WINDOW_LEN = 16,
  parameter int PULSE_LEN  = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       testStart,
  input logic       resultStart,
  input logic       statusPin,
  input logic [2:0] dbgState
);

  localparam logic [2:0] S_RESET  = 3'd0;
  localparam logic [2:0] S_TEST   = 3'd1;
  localparam logic [2:0] S_WINDOW = 3'd2;
  localparam logic [2:0] S_FAIL   = 3'd4;
  localparam logic [2:0] S_PULSE  = 3'd5;
  localparam logic [15:0] WIN_N   = 16'(WINDOW_LEN);
  localparam logic [15:0] PULSE_N = 16'(PULSE_LEN);

  logic        rstQ;
  logic [15:0] winRun;
  logic [15:0] pulseRun;

  always_ff @(posedge clk) rstQ <= rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      winRun   <= '0;
      pulseRun <= '0;
    end else begin
      winRun   <= (dbgState == S_WINDOW) ? winRun + 16'd1 : 16'd0;
      pulseRun <= (dbgState == S_PULSE)  ? pulseRun + 16'd1 : 16'd0;
    end
  end

  // R1: output low after a reset cycle
  always @(negedge clk) begin
    if (rstQ === 1'b1) begin
      p_reset_low_r1: assert (statusPin == 1'b0 && dbgState == S_RESET)
        else $error("reset did not force output low");
    end
  end

  p_test_high_r2: assert property (@(posedge clk) disable iff (rst)
    (dbgState == S_RESET && testStart) |=> (statusPin && dbgState == S_TEST));

  p_window_enter_r3: assert property (@(posedge clk) disable iff (rst)
    (dbgState == S_TEST && resultStart) |=> (!statusPin && dbgState == S_WINDOW));

  p_window_max_r3: assert property (@(posedge clk) disable iff (rst)
    (dbgState == S_WINDOW) |-> (winRun < WIN_N));

  p_window_stay_r3: assert property (@(posedge clk) disable iff (rst)
    (dbgState == S_WINDOW && winRun != WIN_N - 16'd1) |=> (dbgState == S_WINDOW));

  p_fail_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (dbgState == S_FAIL) |=> (dbgState == S_FAIL && statusPin));

  p_pulse_max_r6: assert property (@(posedge clk) disable iff (rst)
    (dbgState == S_PULSE) |-> (pulseRun < PULSE_N && statusPin));

  p_pulse_stay_r10: assert property (@(posedge clk) disable iff (rst)
    (dbgState == S_PULSE && pulseRun != PULSE_N - 16'd1) |=> (dbgState == S_PULSE));

endmodule

bind selftest_hang_indicator selftest_hang_indicator_chk #(
  .WINDOW_LEN (WINDOW_LEN),
  .PULSE_LEN  (PULSE_LEN)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .testStart   (testStart),
  .resultStart (resultStart),
  .statusPin   (statusPin),
  .dbgState    (dbgState)
);

// File: tb/tb_selftest_hang_indicator.sv
module tb_selftest_hang_indicator;

  localparam int CLK_PERIOD = 10;
  localparam int WIN   = 16;
  localparam int LIMIT = 2048;
  localparam int PLEN  = 3;

  logic clk = 1'b0;
  logic rst, testStart, resultStart, testPass, powerUpDone, instRetired;
  logic statusPin;
  logic [2:0] dbgState;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench-side arithmetic of the pass regime
  int idleRun   = 0;
  int pulseLeft = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  selftest_hang_indicator dut (
    .clk(clk), .rst(rst), .testStart(testStart), .resultStart(resultStart),
    .testPass(testPass), .powerUpDone(powerUpDone), .instRetired(instRetired),
    .statusPin(statusPin), .dbgState(dbgState)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input int expPin, input int expState);
    checks++;
    if (int'(statusPin) != expPin || int'(dbgState) != expState) begin
      fails++;
      $display("FAIL %s: pin=%0d state=%0d expected pin=%0d state=%0d",
               tag, statusPin, dbgState, expPin, expState);
    end
  endtask

  // One cycle in the pass regime: drive, advance, update arithmetic, compare.
  task automatic passCycle(input string tag, input logic pud, input logic ret);
    bit wasPulse;
    powerUpDone = pud;
    instRetired = ret;
    step();
    wasPulse = (pulseLeft > 0);
    if (wasPulse) pulseLeft--;
    if (!pud || ret) idleRun = 0;
    else             idleRun++;
    if (!wasPulse && idleRun == LIMIT) begin
      pulseLeft = PLEN;
      idleRun   = 0;
    end
    check(tag, (pulseLeft > 0) ? 1 : 0, (pulseLeft > 0) ? 5 : 3);
  endtask

  task automatic runWindow(input logic verdict, input string tagEnd);
    testPass    = verdict;
    resultStart = 1'b1;
    step();
    resultStart = 1'b0;
    for (int i = 1; i <= WIN; i++) begin
      check("R3", 0, 2);
      step();
    end
    check(tagEnd, verdict ? 0 : 1, verdict ? 3 : 4);
  endtask

  task automatic doReset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    check("R1", 0, 0);
  endtask

  initial begin
    rst = 1'b1; testStart = 0; resultStart = 0; testPass = 0;
    powerUpDone = 0; instRetired = 0;
    step(); step();
    check("R1", 0, 0);
    rst = 1'b0;

    // R2: result strobe ignored before test start
    resultStart = 1'b1; step(); resultStart = 1'b0;
    for (int i = 0; i < 3; i++) begin check("R2", 0, 0); step(); end

    testStart = 1'b1; step(); testStart = 1'b0;
    check("R2", 1, 1);
    for (int i = 0; i < 5; i++) begin step(); check("R2", 1, 1); end
    testStart = 1'b1; step(); testStart = 1'b0;
    check("R2", 1, 1);

    // R3/R5: failing verdict, then stall and strobes have no effect
    runWindow(1'b0, "R5");
    for (int i = 0; i < LIMIT + 100; i++) begin
      powerUpDone = 1'b1;
      instRetired = 1'b0;
      testStart   = (i % 97) == 0;
      resultStart = (i % 89) == 0;
      step();
      check("R5", 1, 4);
    end
    testStart = 0; resultStart = 0; powerUpDone = 0;
    doReset();

    // R4: passing verdict
    testStart = 1'b1; step(); testStart = 1'b0;
    check("R2", 1, 1);
    runWindow(1'b1, "R4");
    idleRun = 0; pulseLeft = 0;
    for (int i = 0; i < 40; i++) passCycle("R4", 1'b0, 1'b0);
    // R11: strobes ignored after the verdict
    testStart = 1'b1; resultStart = 1'b1;
    passCycle("R11", 1'b0, 1'b0);
    testStart = 1'b0; resultStart = 1'b0;

    // R8: no counting while power-up incomplete
    for (int i = 0; i < LIMIT + 200; i++) passCycle("R8", 1'b0, 1'b0);
    for (int i = 0; i < 1000; i++) passCycle("R8", 1'b1, 1'b0);
    passCycle("R8", 1'b0, 1'b0);
    for (int i = 0; i < LIMIT - 1; i++) passCycle("R8", 1'b1, 1'b0);

    // R7: retirement one cycle short of the limit
    passCycle("R7", 1'b1, 1'b1);
    for (int i = 0; i < LIMIT - 1; i++) passCycle("R7", 1'b1, 1'b0);
    passCycle("R7", 1'b1, 1'b1);
    for (int i = 0; i < LIMIT - 1; i++) passCycle("R7", 1'b1, 1'b0);

    // R6: one more idle cycle reaches the limit
    passCycle("R6", 1'b1, 1'b0);
    for (int i = 0; i < PLEN + 5; i++) passCycle("R6", 1'b1, 1'b0);

    // R9: unbroken stall repeats the pulse
    for (int i = 0; i < 2 * LIMIT + 10; i++) passCycle("R9", 1'b1, 1'b0);

    // R10: retire during a pulse
    while (pulseLeft != PLEN) passCycle("R10", 1'b1, 1'b0);
    passCycle("R10", 1'b1, 1'b1);
    for (int i = 0; i < LIMIT + 20; i++) passCycle("R10", 1'b1, 1'b0);

    doReset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule